// File: doc/BRIEF.md
# Periodic Timebase Interrupt Generator

This block divides a slow oscillator clock with a binary counter chain. It raises an interrupt flag each time the chain wraps at one of eight selectable tap positions. Software controls it through one byte-wide control register. The register holds a rate code, a run bit, an interrupt-enable bit and a write-one-to-clear acknowledge bit, and it shows the pending flag. The interrupt request to the CPU is the flag gated by the interrupt-enable bit.

The register and the counter both run in the oscillator clock domain. A typical use is a periodic wake-up tick. Software picks a rate while the block is stopped, then sets the run bit. It services each interrupt by writing the acknowledge bit. Clearing and then setting the run bit restarts the period from zero.

Top module: `tick_irq_gen`

## Requirements
- R1: While reset is asserted, and on the first cycles after its release, the register reads 0x00 and `irq` is 0. The run bit, the interrupt-enable bit, the flag, the rate code and the counter are all cleared.
- R2: Register bit layout: [7] flag, [6:4] rate code, [3] acknowledge, [2] interrupt enable, [1] run, [0] unused. The rate code selects the divide ratio: 0→32768, 1→8192, 2→2048, 3→128, 4→64, 5→32, 6→16, 7→8. A write that sets the run bit from the stopped state is followed by the flag reading 1 exactly N clock edges later, and not one edge earlier.
- R3: While running, the flag is set again every N cycles, counted from the write that set the run bit.
- R4: `irq` is 1 exactly when the flag and the interrupt-enable bit are both 1. Setting the interrupt-enable bit while the flag is pending raises `irq` at that write.
- R5: Writing 1 to bit 3 clears the flag. A write with bit 3 at 0 leaves the flag unchanged. Bit 3 always reads 0.
- R6: When a wrap event and an acknowledge write fall on the same edge, the flag stays set.
- R7: While the run bit is 0, the counter is held at zero. After the run bit is cleared and set again, the next flag arrives N cycles after the re-enabling write, whatever count had been reached before.
- R8: A write to the rate code takes effect only if the run bit was 0 before that write. This includes the write that sets the run bit. Otherwise the code keeps its previous value.
- R9: Writing 1 to bit 7 does not set the flag. Bit 0 always reads 0.
- R10: While the run bit is 0, the flag never becomes set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; all state is in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Data written to the control register |
| rd_data | output | 8 | Current register contents |
| irq | output | 1 | Interrupt request: flag AND interrupt enable |

## Verification
The hardest case to reach from the ports is an acknowledge write that lands on the very edge where the counter wraps. The bench starts the fastest rate at a known edge W. It then schedules the acknowledge write for edge W+8, so the clear and the new event collide. The restart case is similar. The bench stops the counter mid-period and restarts it a few cycles later. A counter that only froze instead of zeroing would then flag too early, and the bench catches this by checking the cycle just before the expected wrap.

// File: rtl/tbg_pkg.sv
package tbg_pkg;

  localparam int TBG_REG_W   = 8;
  localparam int TBG_RATE_W  = 3;
  localparam int TBG_N_RATES = 1 << TBG_RATE_W;

  // Field positions inside the control register
  localparam int POS_FLAG    = 7;
  localparam int POS_RATE_LO = 4;
  localparam int POS_ACK     = 3;
  localparam int POS_IE      = 2;
  localparam int POS_RUN     = 1;

  // log2 of the divide ratio for each rate code
  function automatic int tbg_shift(input int code);
    case (code)
      0:       return 15;
      1:       return 13;
      2:       return 11;
      3:       return 7;
      4:       return 6;
      5:       return 5;
      6:       return 4;
      default: return 3;
    endcase
  endfunction

  localparam int TBG_CNT_W = tbg_shift(0);

endpackage

// File: rtl/tbg_rst_sync.sv
module tbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tbg_divider.sv
module tbg_divider
  import tbg_pkg::*;
#(
  parameter int CNT_W  = TBG_CNT_W,
  parameter int RATE_W = TBG_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  localparam int N_TAPS = 1 << RATE_W;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_ce;
  logic [N_TAPS-1:0] tap_hit;

  // next state: count while running, collapse to zero when stopped
  always_comb begin
    cnt_ce = run || (cnt_q != '0);
    cnt_d  = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // one wrap detector per rate code
  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int SH = tbg_shift(g);
    assign tap_hit[g] = &cnt_q[SH-1:0];
  end

  assign tick = run && tap_hit[rate];

endmodule

// File: rtl/tbg_ctrl.sv
module tbg_ctrl
  import tbg_pkg::*;
#(
  parameter int REG_W  = TBG_REG_W,
  parameter int RATE_W = TBG_RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              tick,
  output logic [RATE_W-1:0] rate,
  output logic              run,
  output logic              ie,
  output logic              flag
);

  logic [RATE_W-1:0] rate_q, rate_d;
  logic              run_q, run_d;
  logic              ie_q, ie_d;
  logic              flag_q, flag_d;
  logic              cfg_ce, rate_ce, flag_ce;
  logic              ack;

  always_comb begin
    cfg_ce  = wr_en;
    rate_ce = wr_en && !run_q;
    ack     = wr_en && wr_data[POS_ACK];
    run_d   = wr_data[POS_RUN];
    ie_d    = wr_data[POS_IE];
    rate_d  = wr_data[POS_RATE_LO +: RATE_W];
    // a new wrap event wins over a simultaneous acknowledge
    flag_ce = tick || ack;
    flag_d  = tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (cfg_ce) begin
      run_q <= run_d;
      ie_q  <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_ce) rate_q <= rate_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign rate = rate_q;
  assign run  = run_q;
  assign ie   = ie_q;
  assign flag = flag_q;

endmodule

// File: rtl/tick_irq_gen.sv
module tick_irq_gen
  import tbg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [TBG_REG_W-1:0] wr_data,
  output logic [TBG_REG_W-1:0] rd_data,
  output logic                 irq
);

  localparam int CNT_W  = TBG_CNT_W;
  localparam int RATE_W = TBG_RATE_W;

  logic              rst_core_n;
  logic              tick_w;
  logic              run_w;
  logic              ie_w;
  logic              flag_w;
  logic [RATE_W-1:0] rate_w;
  logic              unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[POS_FLAG], wr_data[0]};

  tbg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  tbg_ctrl #(.REG_W(TBG_REG_W), .RATE_W(RATE_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick_w),
    .rate    (rate_w),
    .run     (run_w),
    .ie      (ie_w),
    .flag    (flag_w)
  );

  tbg_divider #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_div (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (run_w),
    .rate  (rate_w),
    .tick  (tick_w)
  );

  always_comb begin
    rd_data                           = '0;
    rd_data[POS_FLAG]                 = flag_w;
    rd_data[POS_RATE_LO +: RATE_W]    = rate_w;
    rd_data[POS_IE]                   = ie_w;
    rd_data[POS_RUN]                  = run_w;
  end

  assign irq = flag_w && ie_w;

endmodule

// File: rtl/tbg_chk.sv
module tbg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       tick
);

  // R4
  a_r4_irq_gating: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[7] && rd_data[2]));

  // R5, R9
  a_r5_fixed_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] == 1'b0) && (rd_data[0] == 1'b0));

  // R5
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && !tick) |=> !rd_data[7]);

  // R6
  a_r6_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> rd_data[7]);

  // R8
  a_r8_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |=> $stable(rd_data[6:4]));

  // R9
  a_r9_flag_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && !tick && !rd_data[7]) |=> !rd_data[7]);

  // R10
  a_r10_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[1] && !rd_data[7]) |=> !rd_data[7]);

endmodule

bind tick_irq_gen tbg_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .irq     (irq),
  .tick    (tick_w)
);

// File: tb/tick_irq_gen_tb.sv
module tick_irq_gen_tb;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq;

  int cyc    = 0;
  int n_cmp  = 0;
  int n_bad  = 0;
  bit done   = 0;

  typedef struct {
    int         at;
    logic [7:0] rd;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];

  // log2 of the divide ratio per rate code, from R2
  int sh_tab[8] = '{15, 13, 11, 7, 6, 5, 4, 3};

  tick_irq_gen u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items when their cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (e.at != cyc || rd_data !== e.rd || irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s cycle %0d (due %0d): rd_data=%02h irq=%b expected rd_data=%02h irq=%b",
                 e.tag, cyc, e.at, rd_data, irq, e.rd, e.irq);
      end
    end
  end

  task automatic push(input int at, input logic [7:0] rd, input logic ir, input string tag);
    q.push_back('{at, rd, ir, tag});
  endtask

  // drive a write that lands on posedge number edge_i
  task automatic wr_at(input int edge_i, input logic [7:0] d);
    while (cyc < edge_i - 1) @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int base, d0, w, n;
    logic [7:0] v;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = 8'h00;
    repeat (3) @(negedge clk);
    push(cyc + 1, 8'h00, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    push(cyc + 1, 8'h00, 1'b0, "R1 after release");
    drain();

    // every rate code: first event, ack behaviour, period
    for (int c = 0; c < 8; c++) begin
      n    = 1 << sh_tab[c];
      v    = {1'b0, 3'(c), 4'b0110};
      base = cyc;
      d0   = base + 2;
      w    = d0 + 2;
      push(w,         v,          1'b0, "R8 rate taken while stopped");
      push(w + n - 1, v,          1'b0, "R2 not early");
      push(w + n,     v | 8'h80,  1'b1, "R2 first event");
      push(w + n + 1, v | 8'h80,  1'b1, "R5 ack=0 no effect");
      push(w + n + 2, v,          1'b0, "R5 ack clears");
      push(w + 2*n - 1, v,        1'b0, "R3 not early");
      push(w + 2*n,   v | 8'h80,  1'b1, "R3 period");
      wr_at(d0, 8'h08);
      wr_at(w, v);
      wr_at(w + n + 1, v);
      wr_at(w + n + 2, v | 8'h08);
      drain();
    end

    // R6: acknowledge on the wrap edge, fastest rate
    base = cyc;
    d0   = base + 2;
    w    = d0 + 2;
    push(w + 7, 8'h76, 1'b0, "R6 before wrap");
    push(w + 8, 8'hF6, 1'b1, "R6 collision keeps flag");
    push(w + 9, 8'h76, 1'b0, "R6 later ack clears");
    wr_at(d0, 8'h08);
    wr_at(w, 8'h76);
    wr_at(w + 8, 8'h7E);
    wr_at(w + 9, 8'h7E);
    drain();

    // R4: flag pending with interrupt enable off, then on
    base = cyc;
    d0   = base + 2;
    w    = d0 + 2;
    push(w + 8,  8'hF2, 1'b0, "R4 masked");
    push(w + 9,  8'hF6, 1'b1, "R4 unmasked");
    push(w + 10, 8'h72, 1'b0, "R4 cleared and masked");
    wr_at(d0, 8'h08);
    wr_at(w, 8'h72);
    wr_at(w + 9, 8'h76);
    wr_at(w + 10, 8'h7A);
    drain();

    // R8, R9, R10, R7
    base = cyc;
    d0   = base + 2;
    push(d0 + 1,  8'h02, 1'b0, "R8 code 0 taken with run");
    push(d0 + 2,  8'h02, 1'b0, "R8 change while running ignored");
    push(d0 + 3,  8'h02, 1'b0, "R9 flag bit not writable");
    push(d0 + 4,  8'h00, 1'b0, "R8 stop write keeps rate");
    push(d0 + 5,  8'h70, 1'b0, "R8 rate taken when stopped");
    push(d0 + 45, 8'h70, 1'b0, "R10 no flag while stopped");
    w = d0 + 46;
    push(w,      8'h72, 1'b0, "R7 run");
    push(w + 6,  8'h70, 1'b0, "R7 stopped mid-period");
    push(w + 16, 8'h72, 1'b0, "R7 restart not early");
    push(w + 17, 8'hF2, 1'b0, "R7 restart from zero");
    wr_at(d0, 8'h08);
    wr_at(d0 + 1, 8'h02);
    wr_at(d0 + 2, 8'h72);
    wr_at(d0 + 3, 8'h82);
    wr_at(d0 + 4, 8'h70);
    wr_at(d0 + 5, 8'h70);
    wr_at(w, 8'h72);
    wr_at(w + 6, 8'h70);
    wr_at(w + 9, 8'h72);
    drain();

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end

endmodule